// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command front end of a byte-wide electrically erasable nonvolatile memory. A host drives a simple strobe bus: active-low chip enable, write enable and output enable, an address and a data byte. Each falling write-enable edge inside a chip-enable window is one command write. The block decodes it, moves a state machine through identifier read, erase, erase verify, program and program verify, and latches the address and data a pending operation needs.

The block drives the high-voltage pulse controls for program and erase. It also selects which address the array sees and what a read cycle returns: array data, identifier codes, or verify data. A stop timer counts each pulse in clock cycles. If the host has not ended the pulse with the matching verify command, the timer ends it. The block then waits in a hold state where only that verify command or a reset command is honoured, so the host never has to bound the longest pulse. A verify command that arrives before the minimum pulse length is ignored and the pulse keeps running.

When the high-voltage enable input is low, the block is a plain read-only memory.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rd_mode is 0 (array), hv_prog and hv_erase are low, and rd_data is 0.
- R2: While hv_en is low, every command write is ignored. rd_mode stays 0, no pulse starts, and reads return array data. Dropping hv_en during a pulse ends it at the next clock edge and returns to array mode.
- R3: A read cycle (bus_ce_n and bus_oe_n both low at a clock edge) registers the selected source into rd_data at that edge. rd_data is 0 after any edge without a read.
- R4: Command 0x90 selects identifier mode (rd_mode 1). A read then returns MFR_CODE when bus_addr bit 0 is 0 and DEV_CODE when it is 1.
- R5: Writing 0x20 twice in a row raises hv_erase at the edge of the second write. If the second write is any other value, the block returns to array mode and that value is not taken as a command.
- R6: Command 0x40 arms programming. The next write latches its address onto arr_addr and its data onto op_data, and raises hv_prog at that edge.
- R7: Erase verify (0xA0) or program verify (0xC0) during the matching pulse ends the pulse only once the pulse has been high for at least ERASE_MIN or PROG_MIN cycles. An earlier verify is ignored.
- R8: A pulse that is not ended lasts exactly PROG_MAX (program) or ERASE_MAX (erase) clock cycles.
- R9: After the stop timer ends a pulse, only the matching verify command or 0x00/0xFF is honoured. Every other write, including the other verify command, is ignored.
- R10: 0x00 or 0xFF returns the block to array mode from any state, ending a running pulse at once.
- R11: In array, identifier and verify modes, a write with an unassigned code returns the block to array mode.
- R12: Erase verify latches the write's address. In erase verify (rd_mode 2) and program verify (rd_mode 3), arr_addr carries the latched address, so reads return array data at that address whatever bus_addr is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_en | input | 1 | High voltage present; low makes the block read-only |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low; falling edge takes a command |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | AW | Host address |
| bus_wdata | input | 8 | Host write data / command code |
| arr_rdata | input | 8 | Array sense data for arr_addr |
| rd_data | output | 8 | Registered read data |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 erase verify, 3 program verify |
| arr_addr | output | AW | Address to array: latched address in pulse/verify states, else bus_addr |
| op_data | output | 8 | Latched program data |
| hv_prog | output | 1 | Program pulse active |
| hv_erase | output | 1 | Erase pulse active |

## Verification
The hold state after a stop-timer expiry is hard to reach from the ports. The same is true of the exact cycles where the minimum pulse length is met. Both need long waits with no writes, and a verify at a precisely counted edge. The bench shrinks the pulse limits through parameters. It lets pulses run out while counting high cycles at falling clock edges, and then probes the hold state with commands that must be ignored. It places program-verify writes one edge before and exactly at the minimum. Randomly seeded reads in array and identifier modes cover the read path around these directed runs.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_RST_LO   = 8'h00;
  localparam logic [7:0] CMD_RST_HI   = 8'hFF;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_ERS_VFY  = 8'hA0;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PRG_VFY  = 8'hC0;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_IDENT,
    ST_ERS_SETUP,
    ST_ERS_PULSE,
    ST_ERS_HOLD,
    ST_ERS_VFY,
    ST_PRG_SETUP,
    ST_PRG_PULSE,
    ST_PRG_HOLD,
    ST_PRG_VFY
  } fsm_t;

  typedef enum logic [1:0] {
    RD_ARRAY   = 2'd0,
    RD_IDENT   = 2'd1,
    RD_ERS_VFY = 2'd2,
    RD_PRG_VFY = 2'd3
  } rd_mode_t;

endpackage

// File: rtl/flash_bus_strobe.sv
// Turns a falling write enable inside a chip-enable window into a one-cycle strobe.
module flash_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_stb
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  assign wr_stb = !ce_n && !we_n && we_q;
endmodule

// File: rtl/flash_stop_timer.sv
// Cycle counter for the running pulse: minimum-met and expiry flags.
module flash_stop_timer #(
  parameter int PROG_MIN  = 50,
  parameter int PROG_MAX  = 500,
  parameter int ERASE_MIN = 50000,
  parameter int ERASE_MAX = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic is_erase,
  output logic min_met,
  output logic expired
);
  localparam int LIM_TOP = (ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX;
  localparam int CW      = $clog2(LIM_TOP + 1);
  localparam logic [CW-1:0] P_LAST = CW'(PROG_MAX - 1);
  localparam logic [CW-1:0] E_LAST = CW'(ERASE_MAX - 1);
  localparam logic [CW-1:0] P_MINL = CW'(PROG_MIN - 1);
  localparam logic [CW-1:0] E_MINL = CW'(ERASE_MIN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == (is_erase ? E_LAST : P_LAST));
  assign min_met = run && (cnt >= (is_erase ? E_MINL : P_MINL));
endmodule

// File: rtl/flash_read_path.sv
// Registered read mux: identifier codes or array/verify data.
module flash_read_path
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h4D,
  parameter logic [7:0] DEV_CODE = 8'h2A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       addr0,
  input  rd_mode_t   mode,
  input  logic [7:0] arr_rdata,
  output logic [7:0] rd_data
);
  logic [7:0] src;

  always_comb begin
    if (mode == RD_IDENT) src = addr0 ? DEV_CODE : MFR_CODE;
    else                  src = arr_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                rd_data <= '0;
    else if (!ce_n && !oe_n) rd_data <= src;
    else                    rd_data <= '0;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         AW        = 18,
  parameter logic [7:0] MFR_CODE  = 8'h4D,
  parameter logic [7:0] DEV_CODE  = 8'h2A,
  parameter int         PROG_MIN  = 50,
  parameter int         PROG_MAX  = 500,
  parameter int         ERASE_MIN = 50000,
  parameter int         ERASE_MAX = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hv_en,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic [7:0]    arr_rdata,
  output logic [7:0]    rd_data,
  output logic [1:0]    rd_mode,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    op_data,
  output logic          hv_prog,
  output logic          hv_erase
);
  logic          wr_stb;
  fsm_t          st, st_nx;
  logic          cap_addr, cap_data;
  logic [AW-1:0] op_addr;
  logic          tmr_run, tmr_erase, tmr_min, tmr_exp;
  rd_mode_t      mode;
  logic          is_rst;

  flash_bus_strobe u_strobe (
    .clk(clk), .rst(rst), .ce_n(bus_ce_n), .we_n(bus_we_n), .wr_stb(wr_stb)
  );

  assign tmr_run   = (st == ST_ERS_PULSE) || (st == ST_PRG_PULSE);
  assign tmr_erase = (st == ST_ERS_PULSE);

  flash_stop_timer #(
    .PROG_MIN(PROG_MIN), .PROG_MAX(PROG_MAX),
    .ERASE_MIN(ERASE_MIN), .ERASE_MAX(ERASE_MAX)
  ) u_timer (
    .clk(clk), .rst(rst), .run(tmr_run), .is_erase(tmr_erase),
    .min_met(tmr_min), .expired(tmr_exp)
  );

  assign is_rst = (bus_wdata == CMD_RST_LO) || (bus_wdata == CMD_RST_HI);

  always_comb begin
    st_nx    = st;
    cap_addr = 1'b0;
    cap_data = 1'b0;
    if (!hv_en) begin
      st_nx = ST_ARRAY;
    end else begin
      if (tmr_exp) st_nx = (st == ST_ERS_PULSE) ? ST_ERS_HOLD : ST_PRG_HOLD;
      if (wr_stb) begin
        case (st)
          ST_ERS_SETUP: st_nx = (bus_wdata == CMD_ERASE) ? ST_ERS_PULSE : ST_ARRAY;
          ST_PRG_SETUP: begin
            st_nx    = ST_PRG_PULSE;
            cap_addr = 1'b1;
            cap_data = 1'b1;
          end
          ST_ERS_PULSE, ST_ERS_HOLD: begin
            if (is_rst) st_nx = ST_ARRAY;
            else if (bus_wdata == CMD_ERS_VFY && (st == ST_ERS_HOLD || tmr_min)) begin
              st_nx    = ST_ERS_VFY;
              cap_addr = 1'b1;
            end
          end
          ST_PRG_PULSE, ST_PRG_HOLD: begin
            if (is_rst) st_nx = ST_ARRAY;
            else if (bus_wdata == CMD_PRG_VFY && (st == ST_PRG_HOLD || tmr_min))
              st_nx = ST_PRG_VFY;
          end
          default: begin
            case (bus_wdata)
              CMD_IDENT:   st_nx = ST_IDENT;
              CMD_ERASE:   st_nx = ST_ERS_SETUP;
              CMD_PROG:    st_nx = ST_PRG_SETUP;
              CMD_PRG_VFY: st_nx = ST_PRG_VFY;
              CMD_ERS_VFY: begin
                st_nx    = ST_ERS_VFY;
                cap_addr = 1'b1;
              end
              default:     st_nx = ST_ARRAY;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_ARRAY;
    else     st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_addr <= '0;
      op_data <= '0;
    end else begin
      if (cap_addr) op_addr <= bus_addr;
      if (cap_data) op_data <= bus_wdata;
    end
  end

  always_comb begin
    case (st)
      ST_IDENT:   mode = RD_IDENT;
      ST_ERS_VFY: mode = RD_ERS_VFY;
      ST_PRG_VFY: mode = RD_PRG_VFY;
      default:    mode = RD_ARRAY;
    endcase
  end

  assign rd_mode  = mode;
  assign hv_prog  = (st == ST_PRG_PULSE);
  assign hv_erase = (st == ST_ERS_PULSE);
  assign arr_addr = (st == ST_ERS_VFY || st == ST_PRG_VFY ||
                     st == ST_ERS_PULSE || st == ST_PRG_PULSE) ? op_addr : bus_addr;

  flash_read_path #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_read (
    .clk(clk), .rst(rst), .ce_n(bus_ce_n), .oe_n(bus_oe_n), .addr0(bus_addr[0]),
    .mode(mode), .arr_rdata(arr_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int PROG_MIN  = 50,
  parameter int PROG_MAX  = 500,
  parameter int ERASE_MAX = 500000
) (
  input logic       clk,
  input logic       rst,
  input logic       hv_en,
  input logic       bus_ce_n,
  input logic       bus_we_n,
  input logic       bus_oe_n,
  input logic [7:0] bus_wdata,
  input logic [7:0] rd_data,
  input logic [1:0] rd_mode,
  input logic       hv_prog,
  input logic       hv_erase
);
  int prun, erun;

  always_ff @(posedge clk) begin
    if (rst) begin
      prun <= 0;
      erun <= 0;
    end else begin
      prun <= hv_prog  ? prun + 1 : 0;
      erun <= hv_erase ? erun + 1 : 0;
    end
  end

  // R2
  ro_when_low_chk: assert property (@(posedge clk) disable iff (rst)
    !hv_en |=> (rd_mode == 2'd0 && !hv_prog && !hv_erase));

  // R3
  rd_only_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data != 8'h00) |-> $past(!bus_ce_n && !bus_oe_n));

  // R5
  erase_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_erase) |-> $past(!bus_ce_n && !bus_we_n && hv_en && bus_wdata == 8'h20));

  // R6
  prog_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_prog) |-> $past(!bus_ce_n && !bus_we_n && hv_en));

  // R7
  prog_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hv_prog) && rd_mode == 2'd3) |-> (prun >= PROG_MIN));

  // R8
  prog_max_len_chk: assert property (@(posedge clk) disable iff (rst)
    hv_prog |-> (prun < PROG_MAX));

  // R8
  erase_max_len_chk: assert property (@(posedge clk) disable iff (rst)
    hv_erase |-> (erun < ERASE_MAX));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .PROG_MIN(PROG_MIN), .PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .hv_en(hv_en), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
  .bus_oe_n(bus_oe_n), .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_mode(rd_mode),
  .hv_prog(hv_prog), .hv_erase(hv_erase)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int         AW   = 18;
  localparam logic [7:0] MFR  = 8'h4D;
  localparam logic [7:0] DEV  = 8'h2A;
  localparam int         PMIN = 6;
  localparam int         PMAX = 20;
  localparam int         EMIN = 10;
  localparam int         EMAX = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hv_en = 1'b1;
  logic          bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    arr_rdata;
  logic [7:0]    rd_data;
  logic [1:0]    rd_mode;
  logic [AW-1:0] arr_addr;
  logic [7:0]    op_data;
  logic          hv_prog, hv_erase;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] model_arr(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] exp_id(input logic [AW-1:0] a);
    return a[0] ? DEV : MFR;
  endfunction

  assign arr_rdata = model_arr(arr_addr);

  flash_cmd_ctrl #(
    .AW(AW), .MFR_CODE(MFR), .DEV_CODE(DEV),
    .PROG_MIN(PMIN), .PROG_MAX(PMAX), .ERASE_MIN(EMIN), .ERASE_MAX(EMAX)
  ) u_dut (
    .clk(clk), .rst(rst), .hv_en(hv_en), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .rd_mode(rd_mode), .arr_addr(arr_addr),
    .op_data(op_data), .hv_prog(hv_prog), .hv_erase(hv_erase)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts and ends on a falling clock edge; the write is taken at the edge in between.
  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_ce_n = 1'b0; bus_we_n = 1'b0;
    @(negedge clk);
    bus_we_n = 1'b1; bus_ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    bus_addr = a; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
    @(negedge clk);
    d = rd_data;
    bus_ce_n = 1'b1; bus_oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]    rd;
    logic [AW-1:0] a;
    int            n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_mode", rd_mode, 0);
    chk("R1 hv_prog", hv_prog, 0);
    chk("R1 hv_erase", hv_erase, 0);
    chk("R1 rd_data", rd_data, 0);

    // R3 random array reads, R4 random identifier reads
    for (int i = 0; i < 24; i++) begin
      bit use_id;
      use_id = $urandom_range(0, 1) == 1;
      bus_write('0, use_id ? 8'h90 : 8'hFF);
      a = AW'($urandom);
      bus_read(a, rd);
      if (use_id) chk("R4 identifier read", rd, exp_id(a));
      else        chk("R3 array read", rd, model_arr(a));
      chk("R3 idle rd_data", rd_data, 0);
    end
    bus_write('0, 8'h90);
    bus_read(18'h00100, rd); chk("R4 mfr code", rd, MFR);
    bus_read(18'h00101, rd); chk("R4 dev code", rd, DEV);

    // R11 unknown code returns to array
    bus_write('0, 8'h55);
    chk("R11 unknown code", rd_mode, 0);
    bus_write('0, 8'hC0);
    chk("R11 verify mode entered", rd_mode, 3);
    bus_write('0, 8'h13);
    chk("R11 unknown from verify", rd_mode, 0);

    // R2 read-only without high voltage
    hv_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c;
      case ($urandom_range(0, 5))
        0: c = 8'h90; 1: c = 8'h20; 2: c = 8'h40;
        3: c = 8'hA0; 4: c = 8'hC0; default: c = 8'($urandom);
      endcase
      bus_write(AW'($urandom), c);
      chk("R2 write ignored mode", rd_mode, 0);
    end
    bus_write('0, 8'h20); bus_write('0, 8'h20);
    chk("R2 no erase", hv_erase, 0);
    bus_write('0, 8'h40); bus_write(18'h00777, 8'h12);
    chk("R2 no program", hv_prog, 0);
    a = AW'($urandom);
    bus_read(a, rd);
    chk("R2 array read", rd, model_arr(a));
    hv_en = 1'b1;
    @(negedge clk);

    // R5 erase abort
    bus_write('0, 8'h20);
    bus_write('0, 8'h40);
    chk("R5 abort mode", rd_mode, 0);
    chk("R5 abort no erase", hv_erase, 0);
    bus_write(18'h00321, 8'h77);
    chk("R5 aborted value not a command", hv_prog, 0);

    // R5/R8 erase runs out, R9 hold, R12 erase verify
    bus_write('0, 8'h20);
    bus_write('0, 8'h20);
    chk("R5 erase started", hv_erase, 1);
    n = 1;
    while (hv_erase) begin n++; @(negedge clk); end
    chk("R8 erase length", n, EMAX);
    bus_write('0, 8'h90);
    chk("R9 ident ignored in hold", rd_mode, 0);
    bus_write('0, 8'h40);
    bus_write(18'h00055, 8'h33);
    chk("R9 program ignored in hold", hv_prog, 0);
    bus_write('0, 8'hC0);
    chk("R9 other verify ignored", rd_mode, 0);
    bus_write(18'h01A5C, 8'hA0);
    chk("R9 erase verify from hold", rd_mode, 2);
    bus_read(18'h00003, rd);
    chk("R12 erase verify data", rd, model_arr(18'h01A5C));

    // R6 program setup and latch, R7 early verify ignored
    bus_write('0, 8'h40);
    bus_write(18'h02B17, 8'hE4);
    chk("R6 hv_prog", hv_prog, 1);
    chk("R6 op_data", op_data, 8'hE4);
    chk("R6 arr_addr", arr_addr, 18'h02B17);
    repeat (PMIN - 3) @(negedge clk);
    bus_write('0, 8'hC0);              // taken when pulse has been high PMIN-1 cycles
    chk("R7 early verify ignored", hv_prog, 1);
    chk("R7 early verify mode", rd_mode, 0);
    bus_write('0, 8'hFF);
    chk("R10 reset ends program", hv_prog, 0);

    // R7 verify at exactly the minimum
    bus_write('0, 8'h40);
    bus_write(18'h03C21, 8'h5B);
    repeat (PMIN - 2) @(negedge clk);
    bus_write('0, 8'hC0);              // taken when pulse has been high PMIN cycles
    chk("R7 verify at minimum", rd_mode, 3);
    chk("R7 pulse ended", hv_prog, 0);
    bus_read(18'h00000, rd);
    chk("R12 program verify data", rd, model_arr(18'h03C21));

    // R8 program runs out, R9 hold
    bus_write('0, 8'h40);
    bus_write(18'h00F0F, 8'h81);
    n = 1;
    while (hv_prog) begin n++; @(negedge clk); end
    chk("R8 program length", n, PMAX);
    bus_write('0, 8'hA0);
    chk("R9 erase verify ignored", rd_mode, 0);
    bus_write('0, 8'h90);
    chk("R9 ident ignored", rd_mode, 0);
    bus_write('0, 8'hC0);
    chk("R9 program verify from hold", rd_mode, 3);

    // R10 reset during erase, after an early ignored erase verify (R7)
    bus_write('0, 8'h20);
    bus_write('0, 8'h20);
    bus_write('0, 8'hA0);
    chk("R7 early erase verify ignored", hv_erase, 1);
    bus_write('0, 8'h00);
    chk("R10 reset ends erase", hv_erase, 0);
    chk("R10 reset mode", rd_mode, 0);

    // R2 high voltage drop ends pulse
    bus_write('0, 8'h40);
    bus_write(18'h00444, 8'h09);
    chk("R6 program restarted", hv_prog, 1);
    hv_en = 1'b0;
    @(negedge clk);
    chk("R2 drop ends pulse", hv_prog, 0);
    chk("R2 drop mode", rd_mode, 0);
    hv_en = 1'b1;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule